// File: doc/BRIEF.md
# Prioritized Peripheral Interrupt Controller

This block gathers level-sensitive interrupt request lines from on-chip peripherals and hands the CPU one request at a time. The request it hands over is the highest-priority pending one, given as a valid flag, a 4-bit level and a 5-bit source index. Each source has a 4-bit priority field and a mask bit. A source takes part in arbitration only when it is requesting, it is unmasked, and its priority is not zero. When several sources reach the same top level, the lowest index wins. The winner is registered, so the output follows the inputs and the register contents one clock later.

Software reaches the block over a small word-addressed register bus, with read data returned combinationally. The bus covers four priority words, a read-only view of the raw request lines, a mask word, and a companion clear-only port. The clear-only port lets software unmask individual sources without a read-modify-write. By default the block is built for 30 sources, so the fields and bits above source 29 are reserved. A standby input models a low-power condition. While standby is high, the outgoing request is held off, and the mask and priority contents are left untouched.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every priority field reads 0, the mask word reads 0x000003FF (sources 0 to 9 masked), and irq_valid is 0.
- R2: Priority word k sits at address k (k = 0..3). Source s uses word s/8, bits [4*(s%8)+3 : 4*(s%8)], and each field reads back what was last written.
- R3: Priority fields for source numbers at or above NUM_SRC always read 0, and writing to them has no effect.
- R4: Address 4 reads the live request lines: bit s equals irq_req[s] whatever the mask and priority settings are. Bits at or above NUM_SRC read 0, and writes to this address change nothing.
- R5: Address 5 is the mask word. Bit s set to 1 blocks source s from arbitration, and the word reads back as written.
- R6: At address 6, writing 1 to bit s clears mask bit s, writing 0 to a bit leaves the mask bit alone, and a read returns 0.
- R7: A source is eligible only when its request is high, its mask bit is 0 and its priority field is nonzero. With no eligible source, irq_valid is 0.
- R8: Among eligible sources, the one with the highest priority value wins (15 highest). irq_level carries its value and irq_index carries its number.
- R9: When eligible sources tie on the top level, the one with the lowest index wins.
- R10: The outputs are registered: a change on irq_req or in the registers is visible on the outputs after exactly one rising clock edge.
- R11: While standby is high, irq_valid is 0 and the mask and priority contents are kept. After standby falls, arbitration resumes with the same settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Low-power condition; holds the request output off |
| irq_req | input | NUM_SRC | Level-sensitive peripheral request lines |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_valid | output | 1 | A source is being presented |
| irq_level | output | 4 | Priority value of the winner |
| irq_index | output | 5 | Source number of the winner |

## Verification
Arbitration is driven with one lone source and then with several sources on different levels, so a wrong comparison direction shows up. Two sources on the same level at the extremes of the index range are used to catch a reversed tie-break. A source that is requesting but masked, or that has priority zero, is paired with a lower-level eligible source. This separates the three eligibility terms from one another, and the raw view is read in those same states to confirm that it ignores them. A request change is sampled both before and after a single edge to pin down the one-cycle latency.

// File: rtl/prio_irq_pkg.sv
// Shared constants and types for the prioritized interrupt controller.
// Assumes a 32-bit register bus and 4-bit priority fields.
package prio_irq_pkg;
    localparam int REG_W          = 32;
    localparam int LVL_W          = 4;
    localparam int IDX_W          = 5;
    localparam int ADDR_W         = 3;
    localparam int FIELDS_PER_REG = REG_W / LVL_W;

    // Word addresses; priority words occupy 0..3
    localparam logic [ADDR_W-1:0] ADDR_RAW  = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_MASK = 3'd5;
    localparam logic [ADDR_W-1:0] ADDR_MCLR = 3'd6;

    localparam logic [REG_W-1:0] MASK_RST = 32'h0000_03FF;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] level;
        logic [IDX_W-1:0] index;
    } irq_win_t;
endpackage

// File: rtl/irq_prio_regs.sv
// Priority storage: one 4-bit field per implemented source, packed eight
// to a word at word addresses 0..3. Fields for unimplemented sources do
// not exist, so they read 0 and ignore writes.
// Assumes NUM_SRC <= 32.
module irq_prio_regs
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 30
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [REG_W-1:0]         wdata,
    output logic [NUM_SRC*LVL_W-1:0] prio_flat,
    output logic [REG_W-1:0]         rd_prio
);
    logic [LVL_W-1:0] prio_q [NUM_SRC];

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_field
        localparam int WORD = s / FIELDS_PER_REG;
        localparam int POS  = (s % FIELDS_PER_REG) * LVL_W;

        // Hold this source's priority field; clear on reset, load on word write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_q[s] <= '0;
            end else if (we && (addr == ADDR_W'(WORD))) begin
                prio_q[s] <= wdata[POS +: LVL_W];
            end
        end

        assign prio_flat[s*LVL_W +: LVL_W] = prio_q[s];
    end

    // Assemble the addressed priority word; absent fields stay zero
    always_comb begin
        rd_prio = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (int'(addr) == s / FIELDS_PER_REG) begin
                rd_prio[(s % FIELDS_PER_REG)*LVL_W +: LVL_W] = prio_q[s];
            end
        end
    end
endmodule

// File: rtl/irq_mask_reg.sv
// Per-source mask bits with a direct-write port and a clear-only port.
// Assumes the caller presents only the implemented low NUM_SRC data bits.
// The standby input is observed only to check that it never disturbs the mask.
module irq_mask_reg
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               standby,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] mask_q
);
    localparam logic [NUM_SRC-1:0] RST_VAL = MASK_RST[NUM_SRC-1:0];

    logic wr_mask;
    logic wr_clr;

    assign wr_mask = we && (addr == ADDR_MASK);
    assign wr_clr  = we && (addr == ADDR_MCLR);

    // Update mask: reset pattern, full overwrite, or clear the bits written as 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= RST_VAL;
        end else if (wr_mask) begin
            mask_q <= wdata;
        end else if (wr_clr) begin
            mask_q <= mask_q & ~wdata;
        end
    end

    // R1
    mask_reset_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mask_q == RST_VAL));

    // R6
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((mask_q & $past(wdata)) == '0));

    // R11
    mask_standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && !wr_mask && !wr_clr) |=> $stable(mask_q));
endmodule

// File: rtl/irq_arbiter.sv
// Combinational winner selection. A source is eligible when requesting,
// unmasked and nonzero in priority. The scan runs from the top index down
// and takes a source on greater-or-equal, so ties go to the lowest index.
// Clock and reset feed only the embedded checks.
module irq_arbiter
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 30
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       req,
    input  logic [NUM_SRC-1:0]       mask,
    input  logic [NUM_SRC*LVL_W-1:0] prio_flat,
    output irq_win_t                 win
);
    logic [NUM_SRC-1:0] elig;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_elig
        assign elig[s] = req[s] && !mask[s] && (prio_flat[s*LVL_W +: LVL_W] != '0);
    end

    // Scan sources high index to low, keeping the best level seen
    always_comb begin
        win = '0;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (elig[s] && (prio_flat[s*LVL_W +: LVL_W] >= win.level)) begin
                win.valid = 1'b1;
                win.level = prio_flat[s*LVL_W +: LVL_W];
                win.index = IDX_W'(s);
            end
        end
    end

    logic [REG_W-1:0] elig_ext;
    assign elig_ext = REG_W'(elig);

    // R7
    win_is_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win.valid |-> elig_ext[win.index]);

    // R7
    none_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == '0) |-> !win.valid);
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top of the prioritized interrupt controller: priority and mask storage,
// the raw request view, the read mux, and the registered winner output.
// Assumes NUM_SRC between 1 and 32 and a read bus that samples bus_rdata
// combinationally in the same cycle as bus_addr.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               standby,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [2:0]         bus_addr,
    input  logic               bus_we,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_valid,
    output logic [3:0]         irq_level,
    output logic [4:0]         irq_index
);
    logic [NUM_SRC*LVL_W-1:0] prio_flat;
    logic [REG_W-1:0]         rd_prio;
    logic [NUM_SRC-1:0]       mask_q;
    irq_win_t                 win_d;
    irq_win_t                 win_q;

    irq_prio_regs #(.NUM_SRC(NUM_SRC)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .prio_flat (prio_flat),
        .rd_prio   (rd_prio)
    );

    irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .standby (standby),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata[NUM_SRC-1:0]),
        .mask_q  (mask_q)
    );

    irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (irq_req),
        .mask      (mask_q),
        .prio_flat (prio_flat),
        .win       (win_d)
    );

    // Select read data: priority words, raw requests, mask; all else zero
    always_comb begin
        bus_rdata = rd_prio;
        if (bus_addr == ADDR_RAW) begin
            bus_rdata = REG_W'(irq_req);
        end else if (bus_addr == ADDR_MASK) begin
            bus_rdata = REG_W'(mask_q);
        end
    end

    // Register the winner; standby holds the request off
    always_ff @(posedge clk) begin
        if (!rst_n || standby) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign irq_valid = win_q.valid;
    assign irq_level = win_q.level;
    assign irq_index = win_q.index;

    // R11
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> !irq_valid);

    // R8
    level_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_level != '0));

    // R8
    index_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (int'(irq_index) < NUM_SRC));

    // R10
    output_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!standby && !$past(standby) && $past(rst_n)) |-> (win_q == $past(win_d)));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
// Directed bench for the prioritized interrupt controller.
module prio_irq_ctrl_tb;
    localparam int NUM_SRC = 30;
    localparam realtime HALF = 2.5ns;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               standby = 1'b0;
    logic [NUM_SRC-1:0] irq_req = '0;
    logic [2:0]         bus_addr = '0;
    logic               bus_we = 1'b0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic               irq_valid;
    logic [3:0]         irq_level;
    logic [4:0]         irq_index;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(HALF) clk = ~clk;

    prio_irq_ctrl #(.NUM_SRC(NUM_SRC)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby   (standby),
        .irq_req   (irq_req),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_valid (irq_valid),
        .irq_level (irq_level),
        .irq_index (irq_index)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic check_win(input string tag, input logic v, input logic [3:0] l, input logic [4:0] i);
        check({tag, " valid"}, 32'(irq_valid), 32'(v));
        if (v) begin
            check({tag, " level"}, 32'(irq_level), 32'(l));
            check({tag, " index"}, 32'(irq_index), 32'(i));
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(3'd5, d); check("R1 mask reset", d, 32'h0000_03FF);
        for (int k = 0; k < 4; k++) begin
            rd(3'(k), d); check("R1 priority reset", d, 32'h0);
        end
        rd(3'd4, d); check("R4 raw idle", d, 32'h0);
        check_win("R1 output reset", 1'b0, 4'd0, 5'd0);
    endtask

    task automatic t_field_and_eligibility();
        logic [31:0] d;
        irq_req = NUM_SRC'(1) << 10;
        settle();
        check_win("R7 zero priority blocks", 1'b0, 4'd0, 5'd0);
        wr(3'd1, 32'h0000_0500);            // source 10 -> level 5
        rd(3'd1, d); check("R2 field readback", d, 32'h0000_0500);
        settle();
        check_win("R2 source 10 field", 1'b1, 4'd5, 5'd10);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(3'd0, 32'h0000_F000);            // source 3 -> level 15
        irq_req = irq_req | (NUM_SRC'(1) << 3);
        settle();
        check_win("R5 reset-masked source blocked", 1'b1, 4'd5, 5'd10);
        rd(3'd4, d); check("R4 raw ignores mask", d, 32'h0000_0408);
        wr(3'd6, 32'h0000_0008);
        settle();
        check_win("R6 clear unmasks source 3", 1'b1, 4'd15, 5'd3);
        rd(3'd5, d); check("R6 mask after clear", d, 32'h0000_03F7);
        wr(3'd6, 32'h0000_0000);
        rd(3'd5, d); check("R6 zero write no effect", d, 32'h0000_03F7);
        rd(3'd6, d); check("R6 clear port reads 0", d, 32'h0);
        wr(3'd5, 32'h0000_03FF);
        rd(3'd5, d); check("R5 mask readback", d, 32'h0000_03FF);
        settle();
        check_win("R5 mask reapplied", 1'b1, 4'd5, 5'd10);
    endtask

    task automatic t_priority_and_tie();
        wr(3'd5, 32'h0);
        wr(3'd1, 32'h9000_0000);            // source 15 -> 9
        wr(3'd2, 32'h0007_0000);            // source 20 -> 7
        wr(3'd3, 32'h0000_0090);            // source 25 -> 9
        irq_req = (NUM_SRC'(1) << 15) | (NUM_SRC'(1) << 20) | (NUM_SRC'(1) << 25);
        settle();
        check_win("R9 tie lowest index", 1'b1, 4'd9, 5'd15);
        wr(3'd2, 32'h000C_0000);            // source 20 -> 12
        settle();
        check_win("R8 highest level wins", 1'b1, 4'd12, 5'd20);
        irq_req = (NUM_SRC'(1) << 25);
        settle();
        check_win("R8 lone source", 1'b1, 4'd9, 5'd25);
    endtask

    task automatic t_reserved_and_raw();
        logic [31:0] d;
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, d); check("R3 reserved fields read 0", d, 32'h00FF_FFFF);
        wr(3'd4, 32'hFFFF_FFFF);
        irq_req = '1;
        rd(3'd4, d); check("R4 raw upper bits 0, write ignored", d, 32'h3FFF_FFFF);
        irq_req = '0;
        rd(3'd4, d); check("R4 raw follows lines", d, 32'h0);
        irq_req = (NUM_SRC'(1) << 25) | (NUM_SRC'(1) << 29);
        settle();
        check_win("R9 tie at level 15", 1'b1, 4'd15, 5'd25);
        irq_req = (NUM_SRC'(1) << 29);
        settle();
        check_win("R8 top index", 1'b1, 4'd15, 5'd29);
    endtask

    task automatic t_latency();
        @(negedge clk);
        irq_req = '0;
        #1;
        check_win("R10 before edge", 1'b1, 4'd15, 5'd29);
        @(posedge clk);
        #1;
        check_win("R10 after one edge", 1'b0, 4'd0, 5'd0);
        @(negedge clk);
        irq_req = (NUM_SRC'(1) << 29);
        @(posedge clk);
        #1;
        check_win("R10 rise after one edge", 1'b1, 4'd15, 5'd29);
    endtask

    task automatic t_standby();
        logic [31:0] d;
        wr(3'd5, 32'h0000_1234);
        @(negedge clk);
        standby = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        #1;
        check_win("R11 output held off", 1'b0, 4'd0, 5'd0);
        rd(3'd5, d); check("R11 mask kept", d, 32'h0000_1234);
        rd(3'd3, d); check("R11 priority kept", d, 32'h00FF_FFFF);
        @(negedge clk);
        standby = 1'b0;
        settle();
        check_win("R11 resumes", 1'b1, 4'd15, 5'd29);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_field_and_eligibility();
        t_mask();
        t_priority_and_tie();
        t_reserved_and_raw();
        t_latency();
        t_standby();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule